// File: doc/BRIEF.md
# Tagged Capability Memory Controller

This block is a single-port memory organised as 32-byte granules. Beside each granule it keeps one hidden validity tag that software cannot reach through ordinary stores. A capability access moves a whole granule and its tag in one request. A plain access moves 1, 2, 4 or 8 bytes, and every plain store that reaches memory also drops the tag of the granule it writes. This way a value that has been partly overwritten can never pass as a valid capability.

One reservation register supports a load-reserve / store-conditional pair. A reserving read arms the reservation for its granule. The next conditional store, whether capability or plain, succeeds only if the reservation is still armed for the same granule. One fixed byte address does not reach memory: a plain store to it drives a one-byte output strobe.

Each request is presented for one cycle. Its response appears one cycle later and carries the read data, the tag, a success bit and an error bit.

Top module: `tagmem_ctrl`

## Requirements
- R1: Reset clears every tag and the reservation. While in reset, rsp_valid and out_valid are low.
- R2: Every request cycle produces rsp_valid exactly one cycle later. A cycle with no request produces rsp_valid low one cycle later.
- R3: A capability store writes all 256 data bits and the supplied tag. A capability read returns both the data and the tag.
- R4: Memory is little-endian. Byte address g*32+k holds bits [8k+7:8k] of granule g's capability value. A plain read of size 1, 2, 4 or 8 returns those bytes zero-extended in rsp_rdata.
- R5: A plain store changes only the bytes it covers and clears the granule's tag in the same request.
- R6: A capability access whose address bits [4:0] are not zero sets rsp_err and clears rsp_ok. It leaves data and tag unchanged.
- R7: A plain access with a size other than 1, 2, 4 or 8, or with an address that is not a multiple of its size, sets rsp_err. It changes nothing.
- R8: A read with req_cond=1 arms the reservation for its granule. A store with req_cond=1 succeeds (rsp_ok=1) only when the reservation is armed and its granule matches.
- R9: Every conditional store disarms the reservation, whatever its outcome. A plain or capability store that reaches the reserved granule also disarms it.
- R10: A failed conditional store leaves data and tag unchanged. A successful capability conditional store writes the supplied tag. A successful plain conditional store clears the tag.
- R11: A plain non-conditional store to byte address 0x7F000000 raises out_valid for one cycle, with out_byte equal to req_wdata[7:0]. Memory is left unchanged.
- R12: A store response carries rsp_rdata zero and rsp_tag zero. rsp_ok is 1 for every error-free access except a failed conditional store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = store, 0 = read |
| req_cap | input | 1 | 1 = whole-granule capability access, 0 = plain access |
| req_cond | input | 1 | Read: arm the reservation. Store: conditional store |
| req_addr | input | 64 | Byte address |
| req_size | input | 4 | Plain access size in bytes |
| req_wdata | input | 256 | Store data (a plain store uses the low bytes) |
| req_tag | input | 1 | Tag for a capability store |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 256 | Read data |
| rsp_tag | output | 1 | Tag returned by a capability read |
| rsp_ok | output | 1 | Success bit |
| rsp_err | output | 1 | Alignment or size error |
| out_valid | output | 1 | Output-byte strobe |
| out_byte | output | 8 | Byte written to the output address |

## Verification
Two functions meet in a single plain store to a reserved granule: the same request must clear the tag and disarm the reservation. The bench provokes this with a reserving capability read, then a four-byte plain store into that granule. It then judges the outcome by checking that the next capability conditional store fails and that a capability read returns tag zero with the data intact. A second collision, a plain conditional store that succeeds and clears the tag in the same request, is checked by the same read-back.

// File: rtl/tagmem_ctrl.sv
module tagmem_ctrl #(
  parameter int GRAN_BYTES = 32,
  parameter int NUM_GRAN = 1024,
  parameter logic [63:0] MMIO_ADDR = 64'h0000_0000_7F00_0000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic                      req_cap,
  input  logic                      req_cond,
  input  logic [63:0]               req_addr,
  input  logic [3:0]                req_size,
  input  logic [GRAN_BYTES*8-1:0]   req_wdata,
  input  logic                      req_tag,
  output logic                      rsp_valid,
  output logic [GRAN_BYTES*8-1:0]   rsp_rdata,
  output logic                      rsp_tag,
  output logic                      rsp_ok,
  output logic                      rsp_err,
  output logic                      out_valid,
  output logic [7:0]                out_byte
);
  localparam int GBITS = GRAN_BYTES * 8;
  localparam int OFS_W = $clog2(GRAN_BYTES);
  localparam int IDX_W = $clog2(NUM_GRAN);

  logic [GBITS-1:0]      mem [NUM_GRAN];
  logic [NUM_GRAN-1:0]   tags;
  logic                  resv_v;
  logic [IDX_W-1:0]      resv_idx;

  logic [IDX_W-1:0]      idx;
  logic [OFS_W-1:0]      ofs;
  logic [OFS_W-1:0]      smask;
  logic                  size_ok, err, is_mmio, resv_hit, do_wr;
  logic [GRAN_BYTES-1:0] bmask;
  logic [GBITS-1:0]      wbits, wdata_al, row, plain_rd;

  assign idx   = req_addr[OFS_W +: IDX_W];
  assign ofs   = req_addr[OFS_W-1:0];
  assign smask = OFS_W'(req_size - 4'd1);

  assign size_ok  = (req_size == 4'd1) || (req_size == 4'd2) ||
                    (req_size == 4'd4) || (req_size == 4'd8);
  assign err      = req_cap ? (ofs != '0) : (!size_ok || (ofs & smask) != '0);
  assign is_mmio  = !req_cap && req_write && !req_cond && (req_addr == MMIO_ADDR);
  assign resv_hit = resv_v && (resv_idx == idx);
  assign do_wr    = req_valid && req_write && !err && !is_mmio && (!req_cond || resv_hit);

  assign bmask = req_cap ? '1 :
                 ((GRAN_BYTES'(1) << req_size) - GRAN_BYTES'(1)) << ofs;

  for (genvar g = 0; g < GRAN_BYTES; g++) begin : g_lane
    assign wbits[g*8 +: 8] = {8{bmask[g]}};
  end

  assign wdata_al = req_cap ? req_wdata : (req_wdata << {ofs, 3'b000});
  assign row      = mem[idx];
  assign plain_rd = (row & wbits) >> {ofs, 3'b000};

  always_ff @(posedge clk) begin
    if (do_wr) mem[idx] <= (row & ~wbits) | (wdata_al & wbits);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tags      <= '0;
      resv_v    <= 1'b0;
      resv_idx  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_tag   <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_err   <= 1'b0;
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else begin
      if (do_wr) tags[idx] <= req_cap & req_tag;

      if (req_valid && !err) begin
        if (!req_write && req_cond) begin
          resv_v   <= 1'b1;
          resv_idx <= idx;
        end else if (req_write && req_cond) begin
          resv_v <= 1'b0;
        end else if (do_wr && resv_hit) begin
          resv_v <= 1'b0;
        end
      end

      rsp_valid <= req_valid;
      rsp_err   <= req_valid && err;
      rsp_ok    <= req_valid && !err && (!(req_write && req_cond) || resv_hit);
      rsp_rdata <= (req_valid && !req_write && !err) ? (req_cap ? row : plain_rd) : '0;
      rsp_tag   <= req_valid && !req_write && !err && req_cap && tags[idx];
      out_valid <= req_valid && is_mmio && !err;
      if (req_valid && is_mmio && !err) out_byte <= req_wdata[7:0];
    end
  end
endmodule

// File: rtl/tagmem_ctrl_chk.sv
module tagmem_ctrl_chk #(
  parameter int GBITS = 256,
  parameter int OFS_W = 5,
  parameter logic [63:0] MMIO_ADDR = 64'h0000_0000_7F00_0000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             req_cap,
  input logic [63:0]      req_addr,
  input logic [3:0]       req_size,
  input logic             rsp_valid,
  input logic [GBITS-1:0] rsp_rdata,
  input logic             rsp_tag,
  input logic             rsp_ok,
  input logic             rsp_err,
  input logic             out_valid
);
  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R6
  cap_misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cap && req_addr[OFS_W-1:0] != '0) |=> (rsp_err && !rsp_ok));
  // R7
  size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_cap && req_size != 4'd1 && req_size != 4'd2 &&
     req_size != 4'd4 && req_size != 4'd8) |=> rsp_err);
  // R12
  wr_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (rsp_rdata == '0 && !rsp_tag));
  // R3
  tag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_tag |-> $past(req_valid && req_cap && !req_write));
  // R11
  out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(req_valid && req_write && !req_cap && req_addr == MMIO_ADDR));
endmodule

bind tagmem_ctrl tagmem_ctrl_chk #(.GBITS(GBITS), .OFS_W(OFS_W), .MMIO_ADDR(MMIO_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_cap(req_cap), .req_addr(req_addr), .req_size(req_size),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_tag(rsp_tag),
  .rsp_ok(rsp_ok), .rsp_err(rsp_err), .out_valid(out_valid)
);

// File: tb/sim_tagmem_ctrl.sv
module sim_tagmem_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_cap = 1'b0, req_cond = 1'b0, req_tag = 1'b0;
  logic [63:0] req_addr = '0;
  logic [3:0] req_size = '0;
  logic [255:0] req_wdata = '0;
  logic rsp_valid, rsp_tag, rsp_ok, rsp_err, out_valid;
  logic [255:0] rsp_rdata;
  logic [7:0] out_byte;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tagmem_ctrl u0 (.*);

  typedef struct packed {
    logic wr; logic cap; logic cond;
    logic [31:0] addr; logic [3:0] size; logic tag; logic [63:0] wd;
    logic e_err; logic e_ok; logic e_tag; logic e_out; logic [63:0] e_rd;
    logic [7:0] rq;
  } vec_t;

  localparam logic [63:0] A = 64'h0123456789ABCDEF;
  localparam logic [63:0] B = 64'hFEDCBA9876543210;
  localparam logic [63:0] C = 64'h0F1E2D3C4B5A6978;
  localparam logic [63:0] A2 = 64'h0123456789AB55EF;
  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{1,0,0,32'h00,4'd1,0,64'h3C,0,1,0,0,64'h0,8'd5},              // R5
    '{1,1,0,32'h20,4'd0,1,A,0,1,0,0,64'h0,8'd3},                   // R3
    '{0,1,0,32'h20,4'd0,0,64'h0,0,1,1,0,A,8'd3},                   // R3
    '{0,0,0,32'h20,4'd1,0,64'h0,0,1,0,0,64'hEF,8'd4},              // R4
    '{0,0,0,32'h22,4'd2,0,64'h0,0,1,0,0,64'h89AB,8'd4},            // R4
    '{0,0,0,32'h24,4'd4,0,64'h0,0,1,0,0,64'h01234567,8'd4},        // R4
    '{0,0,0,32'h38,4'd8,0,64'h0,0,1,0,0,A,8'd4},                   // R4
    '{1,0,0,32'h21,4'd1,0,64'h55,0,1,0,0,64'h0,8'd5},              // R5
    '{0,1,0,32'h20,4'd0,0,64'h0,0,1,0,0,A2,8'd5},                  // R5
    '{1,1,0,32'h30,4'd0,1,B,1,0,0,0,64'h0,8'd6},                   // R6
    '{0,1,0,32'h20,4'd0,0,64'h0,0,1,0,0,A2,8'd6},                  // R6
    '{1,0,0,32'h46,4'd4,0,64'h77,1,0,0,0,64'h0,8'd7},              // R7
    '{0,0,0,32'h40,4'd3,0,64'h0,1,0,0,0,64'h0,8'd7},               // R7
    '{1,0,0,32'h7F000000,4'd1,0,64'hA5,0,1,0,1,64'h0,8'd11},       // R11
    '{0,0,0,32'h00,4'd1,0,64'h0,0,1,0,0,64'h3C,8'd11},             // R11
    '{1,1,1,32'h20,4'd0,1,B,0,0,0,0,64'h0,8'd8},                   // R8
    '{0,1,0,32'h20,4'd0,0,64'h0,0,1,0,0,A2,8'd10},                 // R10
    '{0,1,1,32'h20,4'd0,0,64'h0,0,1,0,0,A2,8'd8},                  // R8
    '{1,1,1,32'h20,4'd0,1,B,0,1,0,0,64'h0,8'd8},                   // R8
    '{0,1,0,32'h20,4'd0,0,64'h0,0,1,1,0,B,8'd10},                  // R10
    '{1,1,1,32'h20,4'd0,1,A,0,0,0,0,64'h0,8'd9},                   // R9
    '{0,1,0,32'h20,4'd0,0,64'h0,0,1,1,0,B,8'd9},                   // R9
    '{0,0,1,32'h20,4'd8,0,64'h0,0,1,0,0,B,8'd8},                   // R8
    '{1,0,0,32'h40,4'd8,0,C,0,1,0,0,64'h0,8'd9},                   // R9
    '{1,0,1,32'h28,4'd8,0,C,0,1,0,0,64'h0,8'd10},                  // R10
    '{0,1,0,32'h20,4'd0,0,64'h0,0,1,0,0,B,8'd10},                  // R10
    '{0,1,1,32'h20,4'd0,0,64'h0,0,1,0,0,B,8'd8},                   // R8
    '{1,0,0,32'h30,4'd4,0,64'h11223344,0,1,0,0,64'h0,8'd9},        // R9
    '{1,1,1,32'h20,4'd0,1,A,0,0,0,0,64'h0,8'd9},                   // R9
    '{0,1,0,32'h20,4'd0,0,64'h0,0,1,0,0,B,8'd9},                   // R9
    '{0,1,1,32'h20,4'd0,0,64'h0,0,1,0,0,B,8'd8},                   // R8
    '{1,1,1,32'h40,4'd0,1,A,0,0,0,0,64'h0,8'd8},                   // R8
    '{0,0,0,32'h40,4'd8,0,64'h0,0,1,0,0,C,8'd8}                    // R8
  };

  task automatic issue(input logic wr, cap, cond, input logic [63:0] addr,
                       input logic [3:0] size, input logic tag, input logic [255:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_cap = cap; req_cond = cond;
    req_addr = addr; req_size = size; req_tag = tag; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check(input string rq, input logic [299:0] act, input logic [299:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs idle in reset
    check("R1", {rsp_valid, out_valid}, 2'b00);
    rst_n = 1'b1;
    // R1: tag clear after reset, conditional store fails with no reservation
    issue(0, 1, 0, 64'hA0, 4'd0, 0, '0);
    check("R1", {rsp_valid, rsp_tag, rsp_err}, 3'b100);
    issue(1, 1, 1, 64'hA0, 4'd0, 1, {4{A}});
    check("R1", {rsp_ok, rsp_err}, 2'b00);
    // R2: idle cycle yields no response
    @(negedge clk);
    check("R2", rsp_valid, 1'b0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [255:0] wd;
      v = VEC[i];
      wd = v.cap ? {4{v.wd}} : {192'b0, v.wd};
      issue(v.wr, v.cap, v.cond, {32'b0, v.addr}, v.size, v.tag, wd);
      check($sformatf("R%0d vec%0d", v.rq, i),
            {rsp_valid, rsp_err, rsp_ok, rsp_tag, out_valid, rsp_rdata[63:0]},
            {1'b1, v.e_err, v.e_ok, v.e_tag, v.e_out, v.e_rd});
      if (v.e_out) check("R11 out_byte", out_byte, v.wd[7:0]);
      if (!v.wr && !v.cap && !v.e_err) check("R4 zero-extend", rsp_rdata[255:64], 192'b0);
      if (v.wr) check("R12 store data", rsp_rdata, 256'b0);
    end

    // R3: full-width capability round trip
    issue(1, 1, 0, 64'h60, 4'd0, 1, {B, A, C, B});
    issue(0, 1, 0, 64'h60, 4'd0, 0, '0);
    check("R3 full", {rsp_tag, rsp_rdata}, {1'b1, B, A, C, B});
    // R1: reset in mid-run clears tags and reservation
    issue(0, 1, 1, 64'h60, 4'd0, 0, '0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    issue(0, 1, 0, 64'h60, 4'd0, 0, '0);
    check("R1 tag", {rsp_tag, rsp_rdata}, {1'b0, B, A, C, B});
    issue(1, 1, 1, 64'h60, 4'd0, 1, '0);
    check("R1 resv", rsp_ok, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule